// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Interface

This block is the digital front end of a two-channel 8-bit voltage DAC. A host writes 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The first byte of each word is a set of control flags and the second byte is a sample code. The flags are not decoded as an opcode: each flag acts alone, either loading the sample code into one channel or placing one channel in shutdown.

The serial bits are shifted in on the serial clock. When select rises after a complete word, the word is captured and a toggle carries the event into the system clock domain. There the channel registers, the shutdown flags and the effective output codes all change on the same clock edge. For each channel, the block exposes the stored code, the shutdown flag and the effective code that drives the converter. The effective code is zero while that channel is in shutdown.

Top module: `dual_dac_cmd_if`

## Requirements
- R1: A synchronous active-high reset sets both stored codes to 0, clears both shutdown flags and sets both effective codes to 0.
- R2: Bits are sampled on rising serial clock edges while select is low, most significant first. Within the 16-bit word, bit 15 is the first bit sent and bit 0 is the last. Bits 7..0 carry the sample code, MSB first.
- R3: Word bit 8 set loads the sample code into channel A, and word bit 9 set loads it into channel B. With both bits set, both channels get the same code. With both clear, neither stored code changes.
- R4: Every accepted word writes both shutdown flags: word bit 11 sets the shutdown flag of channel A and word bit 12 sets that of channel B. A clear bit makes that channel active. Loads and shutdowns in one word take effect together.
- R5: While a channel is in shutdown, its effective code is 0 and its stored code is kept. While it is active, its effective code equals its stored code.
- R6: Word bits 15, 14, 13 and 10 have no effect on any output.
- R7: If select rises after fewer than 16 bits, the word is dropped and no output changes.
- R8: If more than 16 bits arrive before select rises, only the last 16 bits are used.
- R9: Select may stay low with the serial clock idle between the two bytes of a word, and the result is the same as for an unbroken word.
- R10: Outputs change only in response to a select rising edge that follows a full word, and they change within 6 system clock cycles of that edge. They do not change while bits are still being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (system clock domain) |
| cs_n | input | 1 | Active-low serial select; its rising edge commits a full word |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| code_a_o | output | 8 | Stored code of channel A |
| code_b_o | output | 8 | Stored code of channel B |
| level_a_o | output | 8 | Effective code of channel A (0 in shutdown) |
| level_b_o | output | 8 | Effective code of channel B (0 in shutdown) |
| sdown_a_o | output | 1 | Channel A shutdown flag |
| sdown_b_o | output | 1 | Channel B shutdown flag |

## Verification
A wrong bit count or a shift register that slips by one bit shows up at the first committed word as a stored code off by a factor of two, or as a flag that is swapped or stuck. A lost or doubled toggle in the domain crossing shows up at the next word as outputs that never change, or that change without any select edge. A stored code wrongly cleared on shutdown stays hidden until the channel is made active again. At that point the effective code comes back as 0 instead of the old value, so the bench always re-activates a channel after shutting it down.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DATA_W  = 8;
  localparam int NCH     = 2;
  localparam int WORD_W  = DATA_W + 8;
  // control-byte flag positions inside the full word
  localparam int POS_LD_A = DATA_W + 0;
  localparam int POS_LD_B = DATA_W + 1;
  localparam int POS_SD_A = DATA_W + 3;
  localparam int POS_SD_B = DATA_W + 4;
endpackage

// File: rtl/dacif_shift.sv
// Serial-clock-domain shifter: counts bits, captures a full word on select rise.
module dacif_shift #(
  parameter int WORD_W = 16
) (
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdin,
  output logic [WORD_W-1:0] word_q,
  output logic              word_tgl
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     bit_cnt;

  always_ff @(posedge sclk) begin
    if (!cs_n) shreg <= {shreg[WORD_W-2:0], sdin};
  end

  // count clears whenever select is high; saturates at a full word
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n)                 bit_cnt <= '0;
    else if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
  end

  // commit only if a complete word was seen in this frame
  always_ff @(posedge cs_n) begin
    if (bit_cnt == FULL) begin
      word_q   <= shreg;
      word_tgl <= ~word_tgl;
    end
  end
endmodule

// File: rtl/dacif_sync.sv
// Toggle synchronizer: turns a level change from another domain into one pulse.
module dacif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES-1:0] chain;
  logic              seen;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], tgl_i};
  end

  always_ff @(posedge clk) begin
    seen <= chain[STAGES-1];
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= chain[STAGES-1] ^ seen;
  end
endmodule

// File: rtl/dacif_chan.sv
// One output channel: stored code, shutdown flag, effective code.
module dacif_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              load,
  input  logic              sd_req,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] level_o,
  output logic              sdown_o
);
  logic [DATA_W-1:0] code_nx;

  always_comb begin
    code_nx = load ? data : code_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= '0;
      level_o <= '0;
      sdown_o <= 1'b0;
    end else if (upd) begin
      code_o  <= code_nx;
      sdown_o <= sd_req;
      level_o <= sd_req ? '0 : code_nx;
    end
  end
endmodule

// File: rtl/dual_dac_cmd_if.sv
module dual_dac_cmd_if
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic [DATA_W-1:0] level_a_o,
  output logic [DATA_W-1:0] level_b_o,
  output logic              sdown_a_o,
  output logic              sdown_b_o
);
  logic [WORD_W-1:0] word_q;
  logic              word_tgl;
  logic              upd_pulse;

  logic [NCH-1:0]             ld_v, sd_v, sdown_v;
  logic [NCH-1:0][DATA_W-1:0] code_v, level_v;

  dacif_shift #(.WORD_W(WORD_W)) shift_i (
    .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
    .word_q(word_q), .word_tgl(word_tgl)
  );

  dacif_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .tgl_i(word_tgl), .pulse_o(upd_pulse)
  );

  assign ld_v = {word_q[POS_LD_B], word_q[POS_LD_A]};
  assign sd_v = {word_q[POS_SD_B], word_q[POS_SD_A]};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dacif_chan #(.DATA_W(DATA_W)) chan_i (
      .clk(clk), .rst(rst), .upd(upd_pulse),
      .load(ld_v[ch]), .sd_req(sd_v[ch]), .data(word_q[DATA_W-1:0]),
      .code_o(code_v[ch]), .level_o(level_v[ch]), .sdown_o(sdown_v[ch])
    );
  end

  assign code_a_o  = code_v[0];
  assign code_b_o  = code_v[1];
  assign level_a_o = level_v[0];
  assign level_b_o = level_v[1];
  assign sdown_a_o = sdown_v[0];
  assign sdown_b_o = sdown_v[1];
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              upd,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic [DATA_W-1:0] lvl_a,
  input logic [DATA_W-1:0] lvl_b,
  input logic              sd_a,
  input logic              sd_b
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (code_a == '0 && code_b == '0 && !sd_a && !sd_b)); // R1

  AST_SD_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    sd_a |-> lvl_a == '0); // R5
  AST_SD_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    sd_b |-> lvl_b == '0); // R5
  AST_ACTIVE_A: assert property (@(posedge clk) disable iff (rst)
    !sd_a |-> lvl_a == code_a); // R5
  AST_ACTIVE_B: assert property (@(posedge clk) disable iff (rst)
    !sd_b |-> lvl_b == code_b); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(upd) |-> ($stable(code_a) && $stable(code_b) &&
                     $stable(sd_a) && $stable(sd_b))); // R10

  AST_SAME_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(code_a) && !$stable(code_b)) |-> code_a == code_b); // R3
endmodule

bind dual_dac_cmd_if dacif_chk #(.DATA_W(dacif_pkg::DATA_W)) chk_i (
  .clk(clk), .rst(rst), .upd(upd_pulse),
  .code_a(code_a_o), .code_b(code_b_o),
  .lvl_a(level_a_o), .lvl_b(level_b_o),
  .sd_a(sdown_a_o), .sd_b(sdown_b_o)
);

// File: tb/dual_dac_cmd_if_tb_top.sv
`timescale 1ns/1ps
module dual_dac_cmd_if_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic [7:0] code_a, code_b, lvl_a, lvl_b;
  logic sd_a, sd_b;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [7:0] ec [2];
  logic       es [2];

  always #2.5 clk = ~clk;

  dual_dac_cmd_if dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .code_a_o(code_a), .code_b_o(code_b),
    .level_a_o(lvl_a), .level_b_o(lvl_b),
    .sdown_a_o(sd_a), .sdown_b_o(sd_b)
  );

  task automatic check_all(input string tag);
    logic [7:0] xla, xlb;
    xla = es[0] ? 8'h00 : ec[0];
    xlb = es[1] ? 8'h00 : ec[1];
    nchk++;
    if (code_a !== ec[0] || code_b !== ec[1] || lvl_a !== xla ||
        lvl_b !== xlb || sd_a !== es[0] || sd_b !== es[1]) begin
      nerr++;
      $display("FAIL %s: got code %h/%h lvl %h/%h sd %b%b, expected code %h/%h lvl %h/%h sd %b%b",
               tag, code_a, code_b, lvl_a, lvl_b, sd_a, sd_b,
               ec[0], ec[1], xla, xlb, es[0], es[1]);
    end
  endtask

  // model: apply a committed 16-bit word
  task automatic model_word(input logic [15:0] w);
    if (w[8]) ec[0] = w[7:0];
    if (w[9]) ec[1] = w[7:0];
    es[0] = w[11];
    es[1] = w[12];
  endtask

  // shift n bits of v (MSB of the n first); optional pause after 8 bits
  task automatic shift_bits(input logic [31:0] v, input int n, input bit split);
    cs_n = 1'b0;
    #20;
    for (int i = n - 1; i >= 0; i--) begin
      sdin = v[i];
      #20 sclk = 1'b1;
      #20 sclk = 1'b0;
      if (split && i == n - 8) #300;
    end
  endtask

  task automatic end_frame();
    #20 cs_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [15:0] w, input bit split);
    shift_bits({16'h0, w}, 16, split);
    end_frame();
    model_word(w);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    ec[0] = 0; ec[1] = 0; es[0] = 0; es[1] = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    #1 check_all("R1 reset state");

    // R2: both load, code 0x80, bit order
    send_word(16'h0380, 1'b0);
    check_all("R2 word 0380");
    send_word(16'h0101, 1'b0);
    check_all("R2 LSB last, A=01");

    // R3: only B, then neither
    send_word(16'h0255, 1'b0);
    check_all("R3 load B only");
    send_word(16'h00AA, 1'b0);
    check_all("R3 no load");

    // R4/R5: shutdown keeps code, release restores
    send_word(16'h1800, 1'b0);
    check_all("R4 both shut down");
    send_word(16'h0000, 1'b0);
    check_all("R5 restore after shutdown");
    send_word(16'h0933, 1'b0);
    check_all("R4 load and shutdown A in one word");

    // R6: UB bits only differ
    send_word(16'hE47C, 1'b0);
    check_all("R6 UB bits set");
    send_word(16'h007C, 1'b0);
    check_all("R6 UB bits clear");

    // R7: short frame dropped
    shift_bits(32'h1FF, 9, 1'b0);
    end_frame();
    check_all("R7 9-bit frame dropped");
    shift_bits(32'h1BFF, 15, 1'b0);
    end_frame();
    check_all("R7 15-bit frame dropped");

    // R8: 24 bits, last 16 used
    shift_bits(32'h00FF_03C3, 24, 1'b0);
    end_frame();
    model_word(16'h03C3);
    check_all("R8 24-bit frame");

    // R9: split transfer
    send_word(16'h015A, 1'b1);
    check_all("R9 split A");
    send_word(16'h12A5, 1'b1);
    check_all("R9 split B with shutdown B");

    // R10: full word shifted but select still low -> no change
    shift_bits({16'h0, 16'h0399}, 16, 1'b0);
    repeat (10) @(posedge clk);
    #1 check_all("R10 no change before select rise");
    end_frame();
    model_word(16'h0399);
    check_all("R10 change after select rise");

    // near-exhaustive sweep over every control byte
    for (int c = 0; c < 256; c++) begin
      logic [15:0] w;
      w = {c[7:0], 8'((c * 37 + 11) & 8'hFF)};
      send_word(w, c[0]);
      check_all("R3/R4/R5/R6 control sweep");
    end

    // R1: reset again after activity
    @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    ec[0] = 0; ec[1] = 0; es[0] = 0; es[1] = 0;
    repeat (2) @(posedge clk);
    #1 check_all("R1 reset after traffic");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule